// File: doc/BRIEF.md
# Core Periphery Scan Chain Register

This block is the serial test data register that sits between a processor core and its package pins. It holds one scan cell for every data bus bit, for every control signal and for every address bit, plus one extra cell for a breakpoint input. Two chains can be selected over these cells. The full periphery chain runs through the data, control and address cells. The short debug chain runs through the data cells and then the breakpoint cell, so the data cells belong to both chains.

The TAP controller and the instruction decoder live outside this block. They present a chain select, a test mode and three strobes (capture, shift, update), and each strobe is sampled on a rising TCK edge. On capture, the selected chain loads either the pin-side or the core-side values. On shift, every cell takes the value of its neighbour nearer TDI. On update, the shift cells are copied into holding latches. In external-test mode the latches drive the pins. In internal-test mode they drive the core. In every other mode the functional signals pass straight through in both directions.

Top module: `periph_scan_reg`

## Requirements
- R1: While reset is low, every scan cell and every holding latch clears to 0. After reset, tdo reads 0 on either chain, and in external-test mode all pin outputs read 0.
- R2: chain_sel is decoded as 2'b01 for the full chain and 2'b10 for the debug chain. The codes 2'b00 and 2'b11 select no chain. With no chain selected, tdo is 0 and all three strobes leave the cells and latches untouched.
- R3: On the full chain, the cell order from tdi to tdo is data bits 0 up to DATA_W-1, then control bits 0 up to CTRL_W-1, then address bits ADDR_W-1 down to 0. Its length is DATA_W+CTRL_W+ADDR_W. tdo always shows the address bit 0 cell, so that bit leaves first after a capture.
- R4: The debug chain holds DATA_W+1 cells: data bits 0 up to DATA_W-1 from tdi, then the breakpoint cell. tdo shows the breakpoint cell, so it leaves first.
- R5: test_mode is decoded as 2'b01 for external test and 2'b10 for internal test. A capture in external-test mode loads pin-side values. A capture in any other mode loads core-side values. The breakpoint cell always captures brk_i.
- R6: An update on the full chain copies the data, control and address cells into their latches. An update on the debug chain copies only the data cells and the breakpoint cell. The control and address latches keep their values.
- R7: In external-test mode, the pin outputs show the data, control and address latches, and the core outputs show the pin inputs.
- R8: In internal-test mode, the core outputs and brk_o show the latches, and the pin outputs show the core inputs.
- R9: In test_mode 2'b00 or 2'b11, every pin output equals the matching core input, every core output equals the matching pin input, and brk_o equals brk_i.
- R10: When strobes coincide on an active chain, capture wins over shift and shift wins over update. Only the winning operation takes place.
- R11: A latch changes only on an update. Capturing and shifting leave every driven output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| chain_sel | input | 2 | Chain select (01 full, 10 debug) |
| test_mode | input | 2 | Test mode (01 external, 10 internal) |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| core_data_i | input | DATA_W | Data bus as driven by the core |
| core_ctrl_i | input | CTRL_W | Control signals as driven by the core |
| core_addr_i | input | ADDR_W | Address bus as driven by the core |
| pin_data_i | input | DATA_W | Data bus as seen at the pins |
| pin_ctrl_i | input | CTRL_W | Control signals as seen at the pins |
| pin_addr_i | input | ADDR_W | Address bus as seen at the pins |
| brk_i | input | 1 | Breakpoint input from outside the core |
| pin_data_o | output | DATA_W | Data toward the pins |
| pin_ctrl_o | output | CTRL_W | Control toward the pins |
| pin_addr_o | output | ADDR_W | Address toward the pins |
| core_data_o | output | DATA_W | Data toward the core |
| core_ctrl_o | output | CTRL_W | Control toward the core |
| core_addr_o | output | ADDR_W | Address toward the core |
| brk_o | output | 1 | Breakpoint toward the core |

## Verification
The assertions assume that chain_sel and test_mode come from a decoder that is already settled when a strobe arrives. The first-bit checks after a capture are therefore not required to hold if the chain changes on the very next edge, and the properties guard those cases explicitly. The bench changes the select, the mode and the parallel inputs only between strobes, always on the falling edge. It raises several strobes in the same cycle only in the priority tests, so every other step performs one defined operation.

// File: rtl/periph_scan_pkg.sv
package periph_scan_pkg;

  typedef enum logic [1:0] {
    CH_NONE = 2'b00,
    CH_FULL = 2'b01,
    CH_DBG  = 2'b10,
    CH_RSVD = 2'b11
  } chain_e;

  typedef enum logic [1:0] {
    TM_FUNC  = 2'b00,
    TM_EXT   = 2'b01,
    TM_INT   = 2'b10,
    TM_FUNC2 = 2'b11
  } tmode_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_CAP   = 2'b01,
    OP_SHIFT = 2'b10,
    OP_UPD   = 2'b11
  } scan_op_e;

  // Resolve coincident strobes: capture, then shift, then update.
  function automatic scan_op_e pick_op(input logic active, input logic cap,
                                       input logic sh, input logic upd);
    if (!active)   return OP_IDLE;
    else if (cap)  return OP_CAP;
    else if (sh)   return OP_SHIFT;
    else if (upd)  return OP_UPD;
    else           return OP_IDLE;
  endfunction

  function automatic logic capture_from_pins(input logic [1:0] mode);
    return mode == TM_EXT;
  endfunction

  function automatic logic latches_to_pins(input logic [1:0] mode);
    return mode == TM_EXT;
  endfunction

  function automatic logic latches_to_core(input logic [1:0] mode);
    return mode == TM_INT;
  endfunction

endpackage

// File: rtl/scan_seg.sv
// A run of scan cells that captures in parallel or shifts one place per edge.
// TOWARD_MSB=1: serial input enters bit 0 and leaves from bit W-1.
// TOWARD_MSB=0: serial input enters bit W-1 and leaves from bit 0.
module scan_seg #(
  parameter int W          = 4,
  parameter bit TOWARD_MSB = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         sh_en,
  input  logic [W-1:0] cap_val,
  input  logic         ser_in,
  output logic [W-1:0] cells,
  output logic         ser_out
);

  logic [W-1:0] shifted;

  generate
    if (TOWARD_MSB) begin : g_up
      always_comb begin
        shifted[0] = ser_in;
        for (int i = 1; i < W; i++) shifted[i] = cells[i-1];
      end
      assign ser_out = cells[W-1];
    end else begin : g_down
      always_comb begin
        shifted[W-1] = ser_in;
        for (int i = 0; i < W-1; i++) shifted[i] = cells[i+1];
      end
      assign ser_out = cells[0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cells <= '0;
    else if (cap_en) cells <= cap_val;
    else if (sh_en)  cells <= shifted;
  end

endmodule

// File: rtl/scan_hold.sv
// Holding latches loaded from the scan cells on an update.
module scan_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (upd_en) q <= d;
  end

endmodule

// File: rtl/scan_drive_mux.sv
// Chooses between pass-through and latch drive for one signal group.
module scan_drive_mux #(
  parameter int W = 4
) (
  input  logic         drive_pins,
  input  logic         drive_core,
  input  logic [W-1:0] core_i,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] lat,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] core_o
);

  assign pin_o  = drive_pins ? lat : core_i;
  assign core_o = drive_core ? lat : pin_i;

endmodule

// File: rtl/periph_scan_reg.sv
module periph_scan_reg
  import periph_scan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int ADDR_W = 32
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic [1:0]        chain_sel,
  input  logic [1:0]        test_mode,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              update_en,
  input  logic              tdi,
  output logic              tdo,
  input  logic [DATA_W-1:0] core_data_i,
  input  logic [CTRL_W-1:0] core_ctrl_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic [DATA_W-1:0] pin_data_i,
  input  logic [CTRL_W-1:0] pin_ctrl_i,
  input  logic [ADDR_W-1:0] pin_addr_i,
  input  logic              brk_i,
  output logic [DATA_W-1:0] pin_data_o,
  output logic [CTRL_W-1:0] pin_ctrl_o,
  output logic [ADDR_W-1:0] pin_addr_o,
  output logic [DATA_W-1:0] core_data_o,
  output logic [CTRL_W-1:0] core_ctrl_o,
  output logic [ADDR_W-1:0] core_addr_o,
  output logic              brk_o
);

  // ---- decoded control, brought out as named wires ----
  chain_e   chain;
  scan_op_e op;
  logic     full_act, dbg_act, chain_act;
  logic     cap_evt, sh_evt, upd_evt;
  logic     take_pins, drv_pins, drv_core;

  assign chain     = chain_e'(chain_sel);
  assign full_act  = (chain == CH_FULL);
  assign dbg_act   = (chain == CH_DBG);
  assign chain_act = full_act | dbg_act;
  assign op        = pick_op(chain_act, capture_en, shift_en, update_en);
  assign cap_evt   = (op == OP_CAP);
  assign sh_evt    = (op == OP_SHIFT);
  assign upd_evt   = (op == OP_UPD);
  assign take_pins = capture_from_pins(test_mode);
  assign drv_pins  = latches_to_pins(test_mode);
  assign drv_core  = latches_to_core(test_mode);

  // ---- scan cells ----
  logic [DATA_W-1:0] data_cells;
  logic [CTRL_W-1:0] ctrl_cells;
  logic [ADDR_W-1:0] addr_cells;
  logic [0:0]        brk_cell;
  logic              data_ser, ctrl_ser, addr_ser, brk_ser;

  // data cells are shared by both chains
  scan_seg #(.W(DATA_W), .TOWARD_MSB(1'b1)) u_data_seg (
    .clk(tck), .rst_n(rst_n),
    .cap_en(cap_evt), .sh_en(sh_evt),
    .cap_val(take_pins ? pin_data_i : core_data_i),
    .ser_in(tdi), .cells(data_cells), .ser_out(data_ser)
  );

  scan_seg #(.W(CTRL_W), .TOWARD_MSB(1'b1)) u_ctrl_seg (
    .clk(tck), .rst_n(rst_n),
    .cap_en(cap_evt & full_act), .sh_en(sh_evt & full_act),
    .cap_val(take_pins ? pin_ctrl_i : core_ctrl_i),
    .ser_in(data_ser), .cells(ctrl_cells), .ser_out(ctrl_ser)
  );

  // address enters at its top bit and leaves from bit 0
  scan_seg #(.W(ADDR_W), .TOWARD_MSB(1'b0)) u_addr_seg (
    .clk(tck), .rst_n(rst_n),
    .cap_en(cap_evt & full_act), .sh_en(sh_evt & full_act),
    .cap_val(take_pins ? pin_addr_i : core_addr_i),
    .ser_in(ctrl_ser), .cells(addr_cells), .ser_out(addr_ser)
  );

  scan_seg #(.W(1), .TOWARD_MSB(1'b1)) u_brk_seg (
    .clk(tck), .rst_n(rst_n),
    .cap_en(cap_evt & dbg_act), .sh_en(sh_evt & dbg_act),
    .cap_val(brk_i),
    .ser_in(data_ser), .cells(brk_cell), .ser_out(brk_ser)
  );

  always_comb begin
    unique case (chain)
      CH_FULL: tdo = addr_ser;
      CH_DBG:  tdo = brk_ser;
      default: tdo = 1'b0;
    endcase
  end

  // ---- holding latches ----
  logic [DATA_W-1:0] data_lat;
  logic [CTRL_W-1:0] ctrl_lat;
  logic [ADDR_W-1:0] addr_lat;
  logic [0:0]        brk_lat;

  scan_hold #(.W(DATA_W)) u_data_hold (
    .clk(tck), .rst_n(rst_n), .upd_en(upd_evt), .d(data_cells), .q(data_lat)
  );
  scan_hold #(.W(CTRL_W)) u_ctrl_hold (
    .clk(tck), .rst_n(rst_n), .upd_en(upd_evt & full_act), .d(ctrl_cells), .q(ctrl_lat)
  );
  scan_hold #(.W(ADDR_W)) u_addr_hold (
    .clk(tck), .rst_n(rst_n), .upd_en(upd_evt & full_act), .d(addr_cells), .q(addr_lat)
  );
  scan_hold #(.W(1)) u_brk_hold (
    .clk(tck), .rst_n(rst_n), .upd_en(upd_evt & dbg_act), .d(brk_cell), .q(brk_lat)
  );

  // ---- output drive ----
  scan_drive_mux #(.W(DATA_W)) u_data_mux (
    .drive_pins(drv_pins), .drive_core(drv_core),
    .core_i(core_data_i), .pin_i(pin_data_i), .lat(data_lat),
    .pin_o(pin_data_o), .core_o(core_data_o)
  );
  scan_drive_mux #(.W(CTRL_W)) u_ctrl_mux (
    .drive_pins(drv_pins), .drive_core(drv_core),
    .core_i(core_ctrl_i), .pin_i(pin_ctrl_i), .lat(ctrl_lat),
    .pin_o(pin_ctrl_o), .core_o(core_ctrl_o)
  );
  scan_drive_mux #(.W(ADDR_W)) u_addr_mux (
    .drive_pins(drv_pins), .drive_core(drv_core),
    .core_i(core_addr_i), .pin_i(pin_addr_i), .lat(addr_lat),
    .pin_o(pin_addr_o), .core_o(core_addr_o)
  );

  assign brk_o = drv_core ? brk_lat[0] : brk_i;

endmodule

// File: rtl/periph_scan_reg_chk.sv
module periph_scan_reg_chk #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int ADDR_W = 32
) (
  input logic              tck,
  input logic              rst_n,
  input logic [1:0]        chain_sel,
  input logic [1:0]        test_mode,
  input logic              capture_en,
  input logic              tdo,
  input logic [DATA_W-1:0] core_data_i,
  input logic [ADDR_W-1:0] core_addr_i,
  input logic [DATA_W-1:0] pin_data_i,
  input logic [ADDR_W-1:0] pin_addr_i,
  input logic              brk_i,
  input logic [DATA_W-1:0] pin_data_o,
  input logic [DATA_W-1:0] core_data_o,
  input logic              brk_o,
  input logic              full_act,
  input logic              dbg_act,
  input logic              upd_evt,
  input logic [DATA_W-1:0] data_cells,
  input logic [ADDR_W-1:0] addr_cells,
  input logic [DATA_W-1:0] data_lat,
  input logic [ADDR_W-1:0] addr_lat
);

  p_idle_tdo_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (chain_sel == 2'b00 || chain_sel == 2'b11) |-> (tdo == 1'b0));

  p_first_addr0_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (chain_sel == 2'b01 && capture_en) |=>
      (chain_sel != 2'b01 ||
       tdo == $past(test_mode == 2'b01 ? pin_addr_i[0] : core_addr_i[0])));

  p_first_brk_r4: assert property (@(posedge tck) disable iff (!rst_n)
    (chain_sel == 2'b10 && capture_en) |=>
      (chain_sel != 2'b10 || tdo == $past(brk_i)));

  p_full_copy_r6: assert property (@(posedge tck) disable iff (!rst_n)
    (full_act && upd_evt) |=> (addr_lat == $past(addr_cells) && data_lat == $past(data_cells)));

  p_dbg_keeps_addr_r6: assert property (@(posedge tck) disable iff (!rst_n)
    (dbg_act && upd_evt) |=> $stable(addr_lat));

  p_ext_core_side_r7: assert property (@(posedge tck) disable iff (!rst_n)
    (test_mode == 2'b01) |-> (core_data_o == pin_data_i));

  p_int_pin_side_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (test_mode == 2'b10) |-> (pin_data_o == core_data_i));

  p_func_pass_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (test_mode == 2'b00 || test_mode == 2'b11) |->
      (pin_data_o == core_data_i && core_data_o == pin_data_i && brk_o == brk_i));

  p_hold_r11: assert property (@(posedge tck) disable iff (!rst_n)
    !upd_evt |=> ($stable(data_lat) && $stable(addr_lat)));

endmodule

bind periph_scan_reg periph_scan_reg_chk #(
  .DATA_W(DATA_W), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/periph_scan_reg_bench.sv
module periph_scan_reg_bench;

  localparam int DW = 4;
  localparam int CW = 2;
  localparam int AW = 4;
  localparam int L  = DW + CW + AW;

  logic          tck = 1'b0;
  logic          rst_n;
  logic [1:0]    chain_sel, test_mode;
  logic          capture_en, shift_en, update_en, tdi;
  logic          tdo;
  logic [DW-1:0] core_data_i, pin_data_i, pin_data_o, core_data_o;
  logic [CW-1:0] core_ctrl_i, pin_ctrl_i, pin_ctrl_o, core_ctrl_o;
  logic [AW-1:0] core_addr_i, pin_addr_i, pin_addr_o, core_addr_o;
  logic          brk_i, brk_o;

  periph_scan_reg #(.DATA_W(DW), .CTRL_W(CW), .ADDR_W(AW)) u_periph_scan_reg (
    .tck(tck), .rst_n(rst_n), .chain_sel(chain_sel), .test_mode(test_mode),
    .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
    .tdi(tdi), .tdo(tdo),
    .core_data_i(core_data_i), .core_ctrl_i(core_ctrl_i), .core_addr_i(core_addr_i),
    .pin_data_i(pin_data_i), .pin_ctrl_i(pin_ctrl_i), .pin_addr_i(pin_addr_i),
    .brk_i(brk_i),
    .pin_data_o(pin_data_o), .pin_ctrl_o(pin_ctrl_o), .pin_addr_o(pin_addr_o),
    .core_data_o(core_data_o), .core_ctrl_o(core_ctrl_o), .core_addr_o(core_addr_o),
    .brk_o(brk_o)
  );

  always #5 tck = ~tck;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model: chain position p counted from tdi (R3 ordering).
  logic [L-1:0]  m_full;
  logic          m_brk;
  logic [DW-1:0] l_data;
  logic [CW-1:0] l_ctrl;
  logic [AW-1:0] l_addr;
  logic          l_brk;

  function automatic logic [DW-1:0] pos_data(input logic [L-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = v[i];
    return r;
  endfunction
  function automatic logic [CW-1:0] pos_ctrl(input logic [L-1:0] v);
    logic [CW-1:0] r;
    for (int j = 0; j < CW; j++) r[j] = v[DW+j];
    return r;
  endfunction
  function automatic logic [AW-1:0] pos_addr(input logic [L-1:0] v);
    logic [AW-1:0] r;
    for (int k = 0; k < AW; k++) r[k] = v[L-1-k];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Apply strobes for one rising edge; update the model; return after the falling edge.
  task automatic step(input logic cap, input logic sh, input logic upd, input logic t);
    logic act_full, act_dbg, ext;
    capture_en = cap; shift_en = sh; update_en = upd; tdi = t;
    act_full = (chain_sel == 2'b01);
    act_dbg  = (chain_sel == 2'b10);
    ext      = (test_mode == 2'b01);
    @(posedge tck);
    if (act_full || act_dbg) begin
      if (cap) begin
        for (int i = 0; i < DW; i++) m_full[i] = ext ? pin_data_i[i] : core_data_i[i];
        if (act_full) begin
          for (int j = 0; j < CW; j++) m_full[DW+j] = ext ? pin_ctrl_i[j] : core_ctrl_i[j];
          for (int k = 0; k < AW; k++) m_full[L-1-k] = ext ? pin_addr_i[k] : core_addr_i[k];
        end else m_brk = brk_i;
      end else if (sh) begin
        if (act_full) m_full = {m_full[L-2:0], t};
        else begin
          m_brk = m_full[DW-1];
          m_full[DW-1:0] = {m_full[DW-2:0], t};
        end
      end else if (upd) begin
        l_data = pos_data(m_full);
        if (act_full) begin
          l_ctrl = pos_ctrl(m_full);
          l_addr = pos_addr(m_full);
        end else l_brk = m_brk;
      end
    end
    @(negedge tck);
    capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0;
  endtask

  task automatic check_drive(input string tag);
    logic to_pins, to_core;
    to_pins = (test_mode == 2'b01);
    to_core = (test_mode == 2'b10);
    chk(tag, pin_data_o,  to_pins ? l_data : core_data_i);
    chk(tag, pin_ctrl_o,  to_pins ? l_ctrl : core_ctrl_i);
    chk(tag, pin_addr_o,  to_pins ? l_addr : core_addr_i);
    chk(tag, core_data_o, to_core ? l_data : pin_data_i);
    chk(tag, core_ctrl_o, to_core ? l_ctrl : pin_ctrl_i);
    chk(tag, core_addr_o, to_core ? l_addr : pin_addr_i);
    chk(tag, brk_o,       to_core ? l_brk  : brk_i);
  endtask

  task automatic set_vals(input int s);
    core_data_i = DW'(s * 3 + 1);
    core_ctrl_i = CW'(s + 1);
    core_addr_i = AW'(s * 7 + 2);
    pin_data_i  = DW'(s * 5 + 6);
    pin_ctrl_i  = CW'(s * 3 + 2);
    pin_addr_i  = AW'(s * 11 + 9);
    brk_i       = s[0] ^ s[2];
  endtask

  // Shift the full chain out while shifting pattern tv in (first bit = tv[0]).
  task automatic shift_full(input string tag, input logic [L-1:0] tv);
    for (int k = 0; k < L; k++) begin
      chk(tag, tdo, m_full[L-1]);
      step(1'b0, 1'b1, 1'b0, tv[k]);
      check_drive("R11");
    end
  endtask

  initial begin
    rst_n = 1'b0; chain_sel = 2'b01; test_mode = 2'b00;
    capture_en = 0; shift_en = 0; update_en = 0; tdi = 0;
    set_vals(0);
    m_full = '0; m_brk = 0; l_data = '0; l_ctrl = '0; l_addr = '0; l_brk = 0;
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    @(negedge tck);

    // R1: reset state
    chk("R1", tdo, 0);
    chain_sel = 2'b10; #1 chk("R1", tdo, 0);
    chain_sel = 2'b01; test_mode = 2'b01; #1;
    chk("R1", pin_data_o, 0); chk("R1", pin_ctrl_o, 0); chk("R1", pin_addr_o, 0);

    // R3 R5 R6 R7 R8: full chain capture, shift, update
    for (int p = 0; p < 8; p++) begin
      set_vals(p + 1);
      test_mode = p[0] ? 2'b01 : 2'b10;
      chain_sel = 2'b01;
      step(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R3/R5 addr0 first", tdo, p[0] ? pin_addr_i[0] : core_addr_i[0]);
      check_drive("R11");
      shift_full("R3", L'(p * 37 + 5));
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check_drive(p[0] ? "R6/R7" : "R6/R8");
    end

    // R4 R5 R6: debug chain; control and address latches must persist
    for (int p = 0; p < 6; p++) begin
      set_vals(p + 20);
      test_mode = p[0] ? 2'b01 : 2'b10;
      chain_sel = 2'b10;
      step(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R4 brk first", tdo, brk_i);
      for (int k = 0; k <= DW; k++) begin
        chk("R4", tdo, m_brk);
        step(1'b0, 1'b1, 1'b0, p[k % 3]);
      end
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check_drive("R6");
      test_mode = 2'b01; #1 check_drive("R6 ext");
      test_mode = 2'b10; #1 check_drive("R6 int");
    end

    // R9: functional pass-through in both pass codes
    for (int p = 0; p < 6; p++) begin
      set_vals(p + 40);
      test_mode = p[0] ? 2'b11 : 2'b00;
      #1 check_drive("R9");
    end

    // R2: unselected chain codes
    chain_sel = 2'b01; test_mode = 2'b01;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    for (int c = 0; c < 2; c++) begin
      chain_sel = c[0] ? 2'b11 : 2'b00;
      set_vals(60 + c);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R2 idle tdo", tdo, 0);
      step(1'b1, 1'b0, 1'b0, 1'b1);
      chk("R2 idle tdo", tdo, 0);
      step(1'b0, 1'b1, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b1, 1'b1);
    end
    chain_sel = 2'b01;
    #1 check_drive("R2");
    shift_full("R2", '0);

    // R10: strobe priority
    set_vals(77);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R10 capture wins", tdo, pin_addr_i[0]);
    check_drive("R10");
    step(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R10 shift wins", tdo, m_full[L-1]);
    check_drive("R10");
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check_drive("R10 update");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule